// File: doc/BRIEF.md
# Synchronous Serial Port with Clock-Stop Master Mode

The block is a master-only synchronous serial port that moves one fixed-length word at a time. The host places a parallel word on its input and pulses a start strobe. The port then shifts the word out MSB first on a serial data pin. At the same time it samples a serial data input into a receive word. When the frame ends, the receive word is presented together with a one-cycle valid pulse. The serial clock comes from the system clock through a programmable divider. The divider sets the half-period H in system cycles, so one serial clock period is always an even number of system cycles.

A two-bit clock-mode code selects how the serial clock behaves. With bit 1 clear, the clock runs without pause and the select output marks only the first bit of each word. With bit 1 set, the port acts as an SPI-style master. The clock rests at its idle level between words and the select output covers the whole word. Code 10b starts clocking at once, while code 11b waits half a period before the first edge.

Two polarity bits control the clock edges. The first fixes the direction of the first clock edge of a word, and the second fixes which edge samples incoming data. A loopback bit turns the transmitted bit stream back into the receiver. This lets the port be tested without any external wiring.

Top module: `spx_serial_port`

## Requirements
- R1: With clock-mode code 10b, the serial clock leaves its idle level in the same system cycle that the select output goes high.
- R2: With code 11b, the select output is high for exactly H system cycles with the clock still at idle before the first clock edge.
- R3: With clock-mode bit 1 set, the clock rests at the level of the transmit polarity bit while no word is in progress, and it is back at that level when select drops. A word spans 16·H system cycles of select high and makes 16 clock transitions.
- R4: Transmit polarity 0 gives an idle-low clock whose first edge in a word is rising; polarity 1 gives an idle-high clock whose first edge is falling.
- R5: Receive polarity 0 samples the data input on rising edges of the internal receive clock, and receive polarity 1 samples it on falling edges. Each sample takes the input level present just before that edge.
- R6: With clock-mode bit 1 clear (codes 00b and 01b), the clock toggles every H cycles even while idle. A word begins at the start of a clock period, with select high for the first bit only (2·H cycles).
- R7: Data out carries word bit 7 first, one bit per clock period. With data in wired to data out, the received word equals the sent word when the receive edge is the mid-bit edge. That is receive polarity equal to transmit polarity for codes 11b/00b/01b, and the opposite polarity for code 10b.
- R8: With loopback set, the received word equals the sent word whatever the data input does, and data out stays 0.
- R9: The valid output is high for exactly one system cycle per word, and the received word is presented in that cycle. In clock-stop mode that cycle is the first one with select low.
- R10: A start strobe that arrives while a word is in progress is ignored. No second word is sent, and the word already in progress is received unchanged.
- R11: After reset the clock, select, data out, busy and valid outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_stop_code | input | 2 | Clock-mode code: 00b/01b continuous, 10b stop immediate, 11b stop half-delayed |
| cfg_tx_pol | input | 1 | Clock idle level / first edge polarity (0: idle low, rising first) |
| cfg_rx_pol | input | 1 | Receive sampling edge (0: rising, 1: falling) |
| cfg_loop | input | 1 | Internal loopback enable |
| cfg_half | input | DIV_W | Serial clock half-period H in system cycles (0 acts as 1) |
| tx_word | input | WORD_W | Word to send, taken when a start is accepted |
| tx_start | input | 1 | Start strobe, accepted only when idle |
| busy | output | 1 | High from accepted start until the word ends |
| rx_word | output | WORD_W | Last received word |
| rx_valid | output | 1 | One-cycle pulse when rx_word is updated |
| ser_clk | output | 1 | Serial clock |
| ser_sel | output | 1 | Frame sync / select |
| ser_dout | output | 1 | Serial data out |
| ser_din | input | 1 | Serial data in |

## Verification
The assertions assume that the configuration inputs change only while busy is low, and that H stays constant during a word. The edge and select relations they check depend on both. The bench changes configuration only between words, after the valid pulse has been seen, and it drives the start strobe only on falling clock edges. The data input is driven from the bench as a constant, as a copy of the serial clock or as a copy of data out. This keeps every sampled level well defined at the sampling tick.

// File: rtl/spx_pkg.sv
package spx_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_PEND = 2'd1,
    SEQ_RUN  = 2'd2
  } seq_state_t;

  // clock-stop operation is selected by the upper code bit
  function automatic logic stop_mode(input logic [1:0] code);
    return code[1];
  endfunction

  // serial clock level during half-period k of a word in clock-stop mode:
  // code 10b is active on even halves, code 11b on odd halves
  function automatic logic half_level(input logic [1:0] code, input logic pol, input int k);
    logic odd;
    odd = k[0];
    if (code == 2'b10) return pol ^ ~odd;
    return pol ^ odd;
  endfunction

  // true when a transition cur->nxt is the sampling edge chosen by rx_pol
  function automatic logic sample_hit(input logic cur, input logic nxt, input logic rx_pol);
    return (cur != nxt) && (nxt ^ rx_pol);
  endfunction

endpackage

// File: rtl/spx_divider.sv
module spx_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] half_len,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] limit;

  assign limit = (half_len == '0) ? '0 : half_len - 1'b1;
  assign tick  = !restart && (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (restart || tick) cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spx_seq.sv
module spx_seq
  import spx_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       start,
  input  logic [1:0] code,
  input  logic       tx_pol,
  input  logic       rx_pol,
  output logic       accept,
  output logic       restart,
  output logic       busy,
  output logic       run,
  output logic       shift_evt,
  output logic       sample_evt,
  output logic       done_evt,
  output logic       sclk,
  output logic       sel
);
  localparam int HALVES = 2 * WORD_W;
  localparam int KW     = $clog2(HALVES + 1);

  seq_state_t      st;
  logic [KW-1:0]   k;
  logic            phase;
  logic            stop;
  logic            last;
  logic            adv;
  logic            nxt_lvl;

  assign stop    = stop_mode(code);
  assign accept  = start && (st == SEQ_IDLE);
  assign restart = accept && stop;
  assign busy    = (st != SEQ_IDLE);
  assign run     = (st == SEQ_RUN);
  assign last    = (k == KW'(HALVES - 1));
  assign adv     = run && tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= SEQ_IDLE;
      k     <= '0;
      phase <= 1'b0;
    end else begin
      if (tick) phase <= ~phase;
      case (st)
        SEQ_IDLE: if (accept) begin
          st <= stop ? SEQ_RUN : SEQ_PEND;
          k  <= '0;
        end
        SEQ_PEND: if (tick && phase) begin
          st <= SEQ_RUN;
          k  <= '0;
        end
        SEQ_RUN: if (tick) begin
          if (last) st <= SEQ_IDLE;
          else      k  <= k + 1'b1;
        end
        default: st <= SEQ_IDLE;
      endcase
    end
  end

  always_comb begin
    if (stop) sclk = run ? half_level(code, tx_pol, int'(k)) : tx_pol;
    else      sclk = tx_pol ^ phase;
    if (stop) nxt_lvl = last ? tx_pol : half_level(code, tx_pol, int'(k) + 1);
    else      nxt_lvl = tx_pol ^ ~phase;
  end

  assign sel        = stop ? run : (run && (k < KW'(2)));
  assign shift_evt  = adv && k[0] && !last;
  assign sample_evt = adv && sample_hit(sclk, nxt_lvl, rx_pol);
  assign done_evt   = adv && last;

  assert_first_edge_now_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sel) && code == 2'b10) |-> (sclk != tx_pol));
  assert_first_edge_late_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sel) && code == 2'b11) |-> (sclk == tx_pol));
  assert_idle_at_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sel) && code[1]) |-> (sclk == tx_pol));
  assert_clock_rests_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (code[1] && !busy && $past(code[1] && !busy) && $stable(tx_pol)) |-> $stable(sclk));
  assert_period_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!code[1] && $rose(sel)) |-> (sclk == tx_pol));
endmodule

// File: rtl/spx_datapath.sv
module spx_datapath #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              run,
  input  logic              shift_evt,
  input  logic              sample_evt,
  input  logic              done_evt,
  input  logic              loop,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              din,
  output logic              dout,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid
);
  logic [WORD_W-1:0] tx_sh;
  logic [WORD_W-1:0] rx_sh;
  logic [WORD_W-1:0] rx_next;
  logic              tx_bit;
  logic              rx_bit;

  assign tx_bit  = tx_sh[WORD_W-1];
  assign rx_bit  = loop ? tx_bit : din;
  assign rx_next = {rx_sh[WORD_W-2:0], rx_bit};
  assign dout    = (run && !loop) ? tx_bit : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh    <= '0;
      rx_sh    <= '0;
      rx_word  <= '0;
      rx_valid <= 1'b0;
    end else begin
      if (accept)         tx_sh <= tx_word;
      else if (shift_evt) tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
      if (accept)          rx_sh <= '0;
      else if (sample_evt) rx_sh <= rx_next;
      if (done_evt) rx_word <= sample_evt ? rx_next : rx_sh;
      rx_valid <= done_evt;
    end
  end

  assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  assert_word_on_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !$past(done_evt)) |-> 1'b0);
endmodule

// File: rtl/spx_serial_port.sv
module spx_serial_port #(
  parameter int WORD_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_stop_code,
  input  logic              cfg_tx_pol,
  input  logic              cfg_rx_pol,
  input  logic              cfg_loop,
  input  logic [DIV_W-1:0]  cfg_half,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              tx_start,
  output logic              busy,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid,
  output logic              ser_clk,
  output logic              ser_sel,
  output logic              ser_dout,
  input  logic              ser_din
);
  logic tick;
  logic accept;
  logic restart;
  logic run;
  logic shift_evt;
  logic sample_evt;
  logic done_evt;

  spx_divider #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .half_len (cfg_half),
    .tick     (tick)
  );

  spx_seq #(.WORD_W(WORD_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .start      (tx_start),
    .code       (cfg_stop_code),
    .tx_pol     (cfg_tx_pol),
    .rx_pol     (cfg_rx_pol),
    .accept     (accept),
    .restart    (restart),
    .busy       (busy),
    .run        (run),
    .shift_evt  (shift_evt),
    .sample_evt (sample_evt),
    .done_evt   (done_evt),
    .sclk       (ser_clk),
    .sel        (ser_sel)
  );

  spx_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .run        (run),
    .shift_evt  (shift_evt),
    .sample_evt (sample_evt),
    .done_evt   (done_evt),
    .loop       (cfg_loop),
    .tx_word    (tx_word),
    .din        (ser_din),
    .dout       (ser_dout),
    .rx_word    (rx_word),
    .rx_valid   (rx_valid)
  );

  assert_loop_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_loop && $stable(cfg_loop)) |-> !ser_dout);
  assert_busy_to_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tx_start) |=> (busy || rx_valid));
endmodule

// File: tb/spx_serial_port_tb.sv
module spx_serial_port_tb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg_stop_code = 2'b10;
  logic       cfg_tx_pol = 1'b0;
  logic       cfg_rx_pol = 1'b0;
  logic       cfg_loop = 1'b0;
  logic [7:0] cfg_half = 8'd3;
  logic [7:0] tx_word = 8'h00;
  logic       tx_start = 1'b0;
  logic       busy, rx_valid, ser_clk, ser_sel, ser_dout, ser_din;
  logic [7:0] rx_word;
  logic [1:0] din_mode = 2'd0;

  int n_checks = 0;
  int n_fail = 0;

  int s_edges, s_fs, s_lead, s_valid, s_dir, s_first, s_sd_any, s_vfall, s_end;
  logic [7:0] s_rx;

  always #(CLK_P/2) clk = ~clk;

  assign ser_din = (din_mode == 2'd2) ? ser_clk :
                   (din_mode == 2'd3) ? ser_dout : din_mode[0];

  spx_serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_stop_code(cfg_stop_code), .cfg_tx_pol(cfg_tx_pol),
    .cfg_rx_pol(cfg_rx_pol), .cfg_loop(cfg_loop), .cfg_half(cfg_half), .tx_word(tx_word),
    .tx_start(tx_start), .busy(busy), .rx_word(rx_word), .rx_valid(rx_valid),
    .ser_clk(ser_clk), .ser_sel(ser_sel), .ser_dout(ser_dout), .ser_din(ser_din)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [1:0] code, input logic txp, input logic rxp,
                         input logic lp, input int half, input logic [1:0] dm);
    @(negedge clk);
    cfg_stop_code = code; cfg_tx_pol = txp; cfg_rx_pol = rxp;
    cfg_loop = lp; cfg_half = 8'(half); din_mode = dm;
    repeat (2) @(negedge clk);
  endtask

  // one word; optional second start strobe at iteration again_at
  task automatic run_frame(input logic [7:0] w, input int ncyc, input int again_at,
                           input logic [7:0] w2);
    logic p_clk, p_fs, seen;
    s_edges = 0; s_fs = 0; s_lead = 0; s_valid = 0; s_dir = 0; s_first = 0;
    s_sd_any = 0; s_vfall = 0; s_rx = 8'h00; seen = 1'b0;
    @(negedge clk);
    tx_word = w; tx_start = 1'b1;
    p_clk = ser_clk; p_fs = ser_sel;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      if ((ser_sel || p_fs) && (ser_clk != p_clk)) begin
        if (!seen) s_dir = int'(ser_clk);
        seen = 1'b1;
        s_edges++;
      end
      if (ser_sel) begin
        s_fs++;
        if (!seen) s_lead++;
        if (s_fs == 1) s_first = int'(ser_dout);
      end
      if (ser_dout) s_sd_any = 1;
      if (rx_valid) begin
        s_valid++; s_rx = rx_word; s_vfall = int'(!ser_sel && p_fs);
      end
      p_clk = ser_clk; p_fs = ser_sel;
      tx_start = (i + 1 == again_at);
      if (i + 1 == again_at) tx_word = w2;
    end
    s_end = int'(ser_clk);
  endtask

  task automatic t_reset;
    chk(ser_clk == 0 && ser_sel == 0 && ser_dout == 0, "R11 pins after reset",
        {ser_clk, ser_sel, ser_dout}, 0);
    chk(busy == 0 && rx_valid == 0, "R11 busy/valid after reset", {busy, rx_valid}, 0);
  endtask

  task automatic t_immediate;
    set_cfg(2'b10, 1'b0, 1'b1, 1'b0, 3, 2'd3);
    run_frame(8'hA5, 130, -1, 8'h00);
    chk(s_lead == 0, "R1 no lead before first edge", s_lead, 0);
    chk(s_edges == 16, "R3 edges per word", s_edges, 16);
    chk(s_fs == 48, "R3 select length", s_fs, 48);
    chk(s_dir == 1, "R4 first edge rising", s_dir, 1);
    chk(s_first == 1, "R7 MSB first", s_first, 1);
    chk(s_rx == 8'hA5, "R7 external wire word", s_rx, 8'hA5);
    chk(s_valid == 1, "R9 one valid pulse", s_valid, 1);
    chk(s_vfall == 1, "R9 valid with select drop", s_vfall, 1);
    chk(s_end == 0, "R3 idle level after word", s_end, 0);
  endtask

  task automatic t_delayed;
    set_cfg(2'b11, 1'b1, 1'b1, 1'b0, 3, 2'd3);
    run_frame(8'h3C, 130, -1, 8'h00);
    chk(s_lead == 3, "R2 half-period lead", s_lead, 3);
    chk(s_dir == 0, "R4 first edge falling", s_dir, 0);
    chk(s_first == 0, "R7 MSB first", s_first, 0);
    chk(s_rx == 8'h3C, "R7 external wire word", s_rx, 8'h3C);
    chk(s_end == 1, "R3 idle high after word", s_end, 1);
    chk(s_edges == 16, "R3 edges per word", s_edges, 16);
  endtask

  task automatic t_rx_edge(input logic [1:0] code);
    set_cfg(code, 1'b0, 1'b0, 1'b0, 3, 2'd2);
    run_frame(8'h55, 130, -1, 8'h00);
    chk(s_rx == 8'h00, "R5 rising edge sees low", s_rx, 8'h00);
    set_cfg(code, 1'b0, 1'b1, 1'b0, 3, 2'd2);
    run_frame(8'h55, 130, -1, 8'h00);
    chk(s_rx == 8'hFF, "R5 falling edge sees high", s_rx, 8'hFF);
  endtask

  task automatic t_stop_idle;
    int ch;
    logic p;
    set_cfg(2'b10, 1'b1, 1'b0, 1'b0, 3, 2'd0);
    ch = 0; p = ser_clk;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (ser_clk != p) ch++;
      p = ser_clk;
    end
    chk(ch == 0 && p == 1'b1, "R3 clock rests while idle", ch, 0);
  endtask

  task automatic t_continuous(input logic [1:0] code, input logic [7:0] w);
    int ch;
    logic p;
    set_cfg(code, 1'b0, 1'b0, 1'b0, 3, 2'd3);
    ch = 0; p = ser_clk;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (ser_clk != p) ch++;
      p = ser_clk;
    end
    chk(ch == 8, "R6 free-running clock while idle", ch, 8);
    run_frame(w, 140, -1, 8'h00);
    chk(s_fs == 6, "R6 select on first bit only", s_fs, 6);
    chk(s_rx == w, "R7 continuous external wire word", s_rx, w);
    chk(s_valid == 1, "R9 one valid pulse", s_valid, 1);
  endtask

  task automatic t_loop;
    set_cfg(2'b11, 1'b0, 1'b0, 1'b1, 3, 2'd1);
    run_frame(8'h5A, 130, -1, 8'h00);
    chk(s_rx == 8'h5A, "R8 loopback word", s_rx, 8'h5A);
    chk(s_sd_any == 0, "R8 data out held low", s_sd_any, 0);
    set_cfg(2'b00, 1'b1, 1'b1, 1'b1, 3, 2'd2);
    run_frame(8'hC3, 140, -1, 8'h00);
    chk(s_rx == 8'hC3, "R8 loopback word continuous", s_rx, 8'hC3);
    chk(s_sd_any == 0, "R8 data out held low", s_sd_any, 0);
  endtask

  task automatic t_busy;
    set_cfg(2'b10, 1'b0, 1'b1, 1'b0, 3, 2'd3);
    run_frame(8'h81, 160, 10, 8'h7E);
    chk(s_valid == 1, "R10 no second word", s_valid, 1);
    chk(s_rx == 8'h81, "R10 first word kept", s_rx, 8'h81);
    chk(s_fs == 48, "R10 single select span", s_fs, 48);
  endtask

  task automatic t_half_one;
    set_cfg(2'b11, 1'b0, 1'b0, 1'b0, 1, 2'd3);
    run_frame(8'hF0, 50, -1, 8'h00);
    chk(s_fs == 16, "R3 select length H=1", s_fs, 16);
    chk(s_lead == 1, "R2 lead H=1", s_lead, 1);
    chk(s_rx == 8'hF0, "R7 word H=1", s_rx, 8'hF0);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_immediate();
    t_delayed();
    t_rx_edge(2'b11);
    t_rx_edge(2'b10);
    t_stop_idle();
    t_continuous(2'b00, 8'h96);
    t_continuous(2'b01, 8'h69);
    t_loop();
    t_busy();
    t_half_one();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule